// File: doc/BRIEF.md
# Pulse-Width Serial Receiver

This block receives a fixed number of bytes from a single shared data line that idles high. Each bit is sent as a low pulse followed by a high phase. A short low pulse means a one and a long low pulse means a zero. The receiver waits for the line to go low. It then lets a fixed number of clock cycles pass and samples the line level. At that point a short pulse has already returned high and a long pulse is still low. Bits are shifted in most significant first, and every eighth bit produces one byte on a single-cycle strobe.

A transfer starts with a one-cycle start strobe that carries the number of bytes expected. It ends with a one-cycle done pulse. Along with that pulse comes a count of the expected bytes that did not arrive complete, so zero means every byte arrived. The receiver gives up early in two cases: the line stays high too long while a falling edge is awaited, or the line stays low too long after a sample. A byte that is only partly shifted in when this happens is dropped.

The line input passes through a two-flop synchronizer. All delays and timeouts are measured from the synchronized level and are set in clock cycles. The defaults assume 16 cycles per microsecond: the sample point comes about 1.8 µs after the falling edge, and each timeout is about 27 µs.

Top module: `pw_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `data_vld_o`, `done_o` and `missing_o` are all zero and the block is idle.
- R2: The line is sampled `SAMPLE_DLY` cycles after the synchronized line is seen low. High means bit value 1 and low means bit value 0. A low pulse of 16 cycles (1 µs) decodes as 1 and a low pulse of 48 cycles (3 µs) decodes as 0. Bits are assembled most significant bit first. Each completed byte appears on `data_o` together with a one-cycle `data_vld_o`, and only while a transfer is in progress.
- R3: Consecutive bytes are received back to back. When the last expected byte is strobed, `done_o` pulses in the same cycle and `missing_o` is 0.
- R4: If the line stays high while a falling edge is awaited, the transfer aborts. When the line is high from the start onward, `done_o` rises exactly `FALL_TIMEOUT` clock edges after the edge that accepted the start.
- R5: If the line stays low for `RISE_TIMEOUT` cycles after a sample, the transfer aborts with `done_o`.
- R6: At `done_o`, `missing_o` equals the expected count minus the number of bytes strobed. A partly received byte is never strobed.
- R7: A start with a byte count of 0 produces `done_o` with `missing_o` = 0 one cycle later, and no byte strobes.
- R8: A start strobe that arrives while a transfer is in progress is ignored, and the ongoing transfer completes unchanged.
- R9: `done_o` lasts exactly one cycle. `missing_o` keeps its value until the next `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe, accepted only when idle |
| byte_cnt_i | input | CNT_W | Number of bytes expected, sampled with `start_i` |
| line_i | input | 1 | Raw level of the data line |
| data_o | output | 8 | Received byte, valid while `data_vld_o` is high |
| data_vld_o | output | 1 | One-cycle strobe for each completed byte |
| done_o | output | 1 | One-cycle pulse when the transfer ends or aborts |
| missing_o | output | CNT_W | Number of expected bytes not fully received |

## Verification
Several internal faults show up at the ports within one bit time (64 cycles). A bit counter that is out of step or a sample point that is misplaced produces wrong bytes or strobes at the wrong positions. A byte counter that is out of step shows at the next `done_o`: the cycle is early or late, or the missing count disagrees with the number of strobes seen. A timer that clears or compares wrongly moves the abort away from the exact `FALL_TIMEOUT` edge, and this is visible on the first aborted transfer. A state machine that accepts a start while busy shows up as a byte that is never emitted and a large missing count.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_FALL   = 2'd1,
    RX_SAMPLE = 2'd2,
    RX_RISE   = 2'd3
  } rx_state_e;
endpackage

// File: rtl/pwrx_sync.sv
module pwrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // line idles high, so reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrx_timer.sv
module pwrx_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwrx_shift.sv
module pwrx_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            bit_i,
  output logic [BITS-1:0] byte_o,
  output logic            last_o
);
  localparam int IDX_W = $clog2(BITS);

  logic [BITS-1:0]  sr_d, sr_q;
  logic [IDX_W-1:0] idx_d, idx_q;

  always_comb begin
    sr_d  = sr_q;
    idx_d = idx_q;
    if (clr_i) begin
      idx_d = '0;
    end else if (en_i) begin
      sr_d  = {sr_q[BITS-2:0], bit_i};
      idx_d = (idx_q == IDX_W'(BITS-1)) ? '0 : idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else begin
      sr_q  <= sr_d;
      idx_q <= idx_d;
    end
  end

  assign byte_o = sr_q;
  assign last_o = (idx_q == IDX_W'(BITS-1));
endmodule

// File: rtl/pw_serial_rx.sv
module pw_serial_rx
  import pwrx_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int FALL_TIMEOUT = 432,
  parameter int RISE_TIMEOUT = 432,
  parameter int SAMPLE_DLY   = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             line_i,
  output logic [7:0]       data_o,
  output logic             data_vld_o,
  output logic             done_o,
  output logic [CNT_W-1:0] missing_o
);
  localparam int TMAX_A = (FALL_TIMEOUT > RISE_TIMEOUT) ? FALL_TIMEOUT : RISE_TIMEOUT;
  localparam int TMAX   = (TMAX_A > SAMPLE_DLY) ? TMAX_A : SAMPLE_DLY;
  localparam int TMR_W  = $clog2(TMAX + 1);

  rx_state_e        state_d, state_q;
  logic [CNT_W-1:0] remain_d, remain_q;
  logic [CNT_W-1:0] miss_d, miss_q;
  logic             vld_d, vld_q, done_d, done_q;
  logic             line_s;
  logic             tmr_clr, tmr_en;
  logic [TMR_W-1:0] tmr_q;
  logic             sh_clr, sh_en, sh_last;
  logic [7:0]       sh_byte;
  logic             busy;

  pwrx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
  );

  pwrx_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .en_i(tmr_en), .cnt_o(tmr_q)
  );

  pwrx_shift #(.BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(sh_clr), .en_i(sh_en),
    .bit_i(line_s), .byte_o(sh_byte), .last_o(sh_last)
  );

  logic fall_exp, rise_exp, smp_hit;
  assign fall_exp = (tmr_q == TMR_W'(FALL_TIMEOUT - 1));
  assign rise_exp = (tmr_q == TMR_W'(RISE_TIMEOUT - 1));
  assign smp_hit  = (tmr_q == TMR_W'(SAMPLE_DLY - 1));

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    miss_d   = miss_q;
    vld_d    = 1'b0;
    done_d   = 1'b0;
    tmr_clr  = 1'b0;
    tmr_en   = 1'b0;
    sh_clr   = 1'b0;
    sh_en    = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        tmr_clr = 1'b1;
        if (start_i) begin
          sh_clr = 1'b1;
          if (byte_cnt_i == '0) begin
            done_d = 1'b1;
            miss_d = '0;
          end else begin
            remain_d = byte_cnt_i;
            state_d  = RX_FALL;
          end
        end
      end
      RX_FALL: begin
        if (!line_s) begin
          tmr_clr = 1'b1;
          state_d = RX_SAMPLE;
        end else if (fall_exp) begin
          done_d  = 1'b1;
          miss_d  = remain_q;
          state_d = RX_IDLE;
        end else begin
          tmr_en = 1'b1;
        end
      end
      RX_SAMPLE: begin
        if (smp_hit) begin
          sh_en   = 1'b1;
          tmr_clr = 1'b1;
          state_d = RX_RISE;
          if (sh_last) begin
            vld_d    = 1'b1;
            remain_d = remain_q - CNT_W'(1);
            if (remain_q == CNT_W'(1)) begin
              done_d  = 1'b1;
              miss_d  = '0;
              state_d = RX_IDLE;
            end
          end
        end else begin
          tmr_en = 1'b1;
        end
      end
      RX_RISE: begin
        if (line_s) begin
          tmr_clr = 1'b1;
          state_d = RX_FALL;
        end else if (rise_exp) begin
          done_d  = 1'b1;
          miss_d  = remain_q;
          state_d = RX_IDLE;
        end else begin
          tmr_en = 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      remain_q <= '0;
      miss_q   <= '0;
      vld_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      miss_q   <= miss_d;
      vld_q    <= vld_d;
      done_q   <= done_d;
    end
  end

  assign busy       = (state_q != RX_IDLE);
  assign data_o     = sh_byte;
  assign data_vld_o = vld_q;
  assign done_o     = done_q;
  assign missing_o  = miss_q;
endmodule

// File: rtl/pw_serial_rx_chk.sv
module pw_serial_rx_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CNT_W-1:0] byte_cnt_i,
  input logic             busy,
  input logic             data_vld_o,
  input logic             done_o,
  input logic [CNT_W-1:0] missing_o
);
  logic [CNT_W:0] exp_q, got_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      got_q <= '0;
    end else if (start_i && !busy) begin
      exp_q <= {1'b0, byte_cnt_i};
      got_q <= '0;
    end else if (data_vld_o) begin
      got_q <= got_q + (CNT_W+1)'(1);
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_missing_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(missing_o));

  assert_vld_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |-> $past(busy));

  assert_tally_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (got_q + (CNT_W+1)'(data_vld_o) + {1'b0, missing_o} == exp_q));

  assert_zero_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && byte_cnt_i == '0) |=> (done_o && missing_o == '0));
endmodule

bind pw_serial_rx pw_serial_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
  .busy(busy), .data_vld_o(data_vld_o), .done_o(done_o), .missing_o(missing_o)
);

// File: tb/pw_serial_rx_tb_top.sv
`timescale 1ns/1ps
module pw_serial_rx_tb_top;
  localparam int CNT_W = 8;
  localparam int FT    = 432;
  localparam int RT    = 432;
  localparam int SD    = 28;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [CNT_W-1:0] byte_cnt_i;
  logic             line_i;
  logic [7:0]       data_o;
  logic             data_vld_o, done_o;
  logic [CNT_W-1:0] missing_o;

  always #10 clk = ~clk;

  pw_serial_rx #(.CNT_W(CNT_W), .FALL_TIMEOUT(FT), .RISE_TIMEOUT(RT), .SAMPLE_DLY(SD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
    .line_i(line_i), .data_o(data_o), .data_vld_o(data_vld_o),
    .done_o(done_o), .missing_o(missing_o)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0] got [0:7];
  int got_n;
  int done_n;
  logic [CNT_W-1:0] miss_seen;

  // fields: count[32:29], bits to send[28:24], data[23:0] msb first
  localparam int NV = 6;
  localparam logic [32:0] VEC [NV] = '{
    {4'd1, 5'd8,  24'hA50000},
    {4'd2, 5'd16, 24'h00FF00},
    {4'd3, 5'd24, 24'h80017E},
    {4'd2, 5'd12, 24'hC3F000},
    {4'd3, 5'd0,  24'h000000},
    {4'd1, 5'd5,  24'h5A0000}
  };

  always @(negedge clk) begin
    if (data_vld_o && got_n < 8) begin
      got[got_n] = data_o;
      got_n++;
    end
    if (done_o) begin
      done_n++;
      miss_seen = missing_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit b);
    line_i = 1'b0;
    repeat (b ? 16 : 48) @(negedge clk);
    line_i = 1'b1;
    repeat (b ? 48 : 16) @(negedge clk);
  endtask

  task automatic begin_rx(input int cnt);
    got_n  = 0;
    done_n = 0;
    @(negedge clk);
    byte_cnt_i = CNT_W'(cnt);
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && done_n == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; byte_cnt_i = '0; line_i = 1'b1;
    got_n = 0; done_n = 0; miss_seen = '0;
    repeat (3) @(negedge clk);
    check(!data_vld_o && !done_o && missing_o == 0, "R1 in reset", int'(missing_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!data_vld_o && !done_o && missing_o == 0, "R1 after reset", int'(done_o), 0);

    // vector table: R2, R3, R6
    for (int v = 0; v < NV; v++) begin
      int cnt, nb, full;
      cnt  = int'(VEC[v][32:29]);
      nb   = int'(VEC[v][28:24]);
      full = nb / 8;
      if (full > cnt) full = cnt;
      begin_rx(cnt);
      for (int i = 0; i < nb; i++) send_bit(VEC[v][23-i]);
      wait_done();
      check(got_n == full, "R6 byte count", got_n, full);
      for (int k = 0; k < full && k < got_n; k++)
        check(got[k] == VEC[v][23-8*k -: 8], "R2 byte value", int'(got[k]), int'(VEC[v][23-8*k -: 8]));
      check(int'(miss_seen) == cnt - full, "R3 R6 missing", int'(miss_seen), cnt - full);
      check(done_n == 1, "R9 one done pulse", done_n, 1);
    end

    // R4 exact fall timeout
    got_n = 0; done_n = 0;
    @(negedge clk);
    byte_cnt_i = 8'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    begin
      int n;
      n = 0;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        n++;
        if (done_o) break;
      end
      check(n == FT, "R4 timeout edge", n, FT);
      check(missing_o == 2, "R4 missing", int'(missing_o), 2);
    end
    repeat (3) @(negedge clk);

    // R7 zero count
    got_n = 0; done_n = 0;
    @(negedge clk);
    byte_cnt_i = 8'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o && missing_o == 0, "R7 zero count done", int'(done_o), 1);
    repeat (3) @(negedge clk);
    check(got_n == 0 && done_n == 1, "R7 no bytes", got_n, 0);

    // R5 rise timeout: line held low
    begin_rx(2);
    line_i = 1'b0;
    repeat (700) @(negedge clk);
    check(done_n == 1 && miss_seen == 2, "R5 rise timeout", int'(miss_seen), 2);
    line_i = 1'b1;
    repeat (20) @(negedge clk);
    check(missing_o == 2 && !done_o, "R9 missing holds", int'(missing_o), 2);
    check(got_n == 0, "R6 partial dropped", got_n, 0);

    // R8 start while busy ignored
    begin_rx(1);
    for (int i = 0; i < 4; i++) send_bit(1'(8'h96 >> (7 - i)));
    byte_cnt_i = 8'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 4; i < 8; i++) send_bit(1'(8'h96 >> (7 - i)));
    wait_done();
    check(got_n == 1 && got[0] == 8'h96, "R8 byte kept", int'(got[0]), 8'h96);
    check(miss_seen == 0, "R8 missing", int'(miss_seen), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule